// File: doc/BRIEF.md
# Digital Oscillator Trim Pulse Adjuster

This block sits between the raw 32.768 kHz oscillator tick and the prescaler of a real-time clock. It corrects the timekeeping rate digitally. It counts raw ticks in fixed windows and, under a signed three-bit trim code, either inserts whole extra pulses into the stream or removes whole pulses from it. This nudges the average rate up or down in equal steps. With the default window of 100,000 ticks, each step is 10 ppm, so the full range is ±30 ppm.

Raw ticks arrive as one-cycle strobes in the system clock domain. The corrected stream leaves as one-cycle strobes one cycle later. Adjustments are spread across each window at fixed tick positions. A trim code written part-way through a window is applied only from the next window onward.

Top module: `trim_adjuster`

## Requirements
- R1: After reset, `tick_out` is low and the applied trim code is zero, so the first window after reset passes exactly `WINDOW_TICKS` pulses.
- R2: With no adjustment active, each raw tick on `tick_in` appears on `tick_out` exactly one clock cycle later.
- R3: Trim code bit 2 = 0 with magnitude m in bits 1:0 adds m pulses per window: the window yields `WINDOW_TICKS` + m output pulses.
- R4: Trim code bit 2 = 1 with magnitude m skips m pulses per window, yielding `WINDOW_TICKS` − m pulses. Code 3'b100 makes no adjustment.
- R5: With SLOT = floor(`WINDOW_TICKS`/4), the k-th adjustment (k = 0..m−1) is made at window tick index k·SLOT + SLOT − 1. Index 0 is the first tick of the window.
- R6: An inserted pulse follows the output pulse of the tick that triggered it by `MIN_TICK_GAP`/2 clock cycles.
- R7: `tick_out` is never high in two consecutive cycles.
- R8: A trim code change takes effect only at the next window boundary. The window in progress keeps the code that was sampled when it started.
- R9: A skipped raw tick produces no output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Raw oscillator tick strobe, one cycle wide |
| trim_code | input | 3 | Signed trim code: bit 2 is the direction, bits 1:0 the step count |
| tick_out | output | 1 | Corrected tick strobe to the prescaler |

## Verification
The bench builds the block with `WINDOW_TICKS` = 40 and `MIN_TICK_GAP` = 8. This makes the slots ten ticks long and the insert delay four cycles. At that size, every window boundary, each of the three adjustment positions, and a code change in mid-window can be reached within a few thousand cycles. Raw ticks are fed every ten cycles, so a per-tick pulse count shows exactly which tick index gains or loses a pulse.

// File: rtl/trim_pkg.sv
package trim_pkg;
   typedef enum logic {
      DIR_FAST = 1'b0,
      DIR_SLOW = 1'b1
   } trim_dir_e;
endpackage

// File: rtl/trim_window_ctr.sv
module trim_window_ctr
   import trim_pkg::*;
#(
   parameter int WINDOW_TICKS = 100000,
   parameter int CODE_W       = 3,
   parameter bit SPREAD       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [CODE_W-1:0] trim_code,
   output logic              skip_now,
   output logic              insert_now
);
   localparam int MAG_W     = CODE_W - 1;
   localparam int MAX_STEPS = (1 << MAG_W) - 1;
   localparam int SLOT      = WINDOW_TICKS / (MAX_STEPS + 1);
   localparam int IDX_W     = $clog2(WINDOW_TICKS);
   localparam int SUB_W     = $clog2(SLOT);

   initial begin
      if (CODE_W < 2) $error("CODE_W must be at least 2");
      if (WINDOW_TICKS < 2 * (MAX_STEPS + 1)) $error("WINDOW_TICKS too small for the step count");
   end

   logic [IDX_W-1:0]  idx_q;
   logic [CODE_W-1:0] code_q;
   logic              wrap;
   logic              due;
   trim_dir_e         dir;
   logic [IDX_W-1:0]  mag;

   assign wrap = tick_in && (idx_q == IDX_W'(WINDOW_TICKS - 1));
   assign dir  = trim_dir_e'(code_q[CODE_W-1]);
   assign mag  = IDX_W'(code_q[MAG_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         code_q <= '0;
      end else if (tick_in) begin
         idx_q <= wrap ? '0 : idx_q + 1'b1;
         if (wrap) code_q <= trim_code;
      end
   end

   generate
      if (SPREAD) begin : g_spread
         logic [SUB_W-1:0] sub_q;
         logic [IDX_W-1:0] slot_q;
         logic             sub_end;
         assign sub_end = (sub_q == SUB_W'(SLOT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub_q  <= '0;
               slot_q <= '0;
            end else if (tick_in) begin
               if (wrap) begin
                  sub_q  <= '0;
                  slot_q <= '0;
               end else if (sub_end) begin
                  sub_q  <= '0;
                  slot_q <= slot_q + 1'b1;
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
         end
         assign due = sub_end && (slot_q < mag);
         assert_sub_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sub_q <= SUB_W'(SLOT - 1));
      end else begin : g_bunched
         assign due = (idx_q < mag);
      end
   endgenerate

   assign skip_now   = tick_in && due && (dir == DIR_SLOW);
   assign insert_now = tick_in && due && (dir == DIR_FAST);

   assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_in && idx_q == IDX_W'(WINDOW_TICKS - 1)) |=> $stable(code_q));
   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(WINDOW_TICKS - 1));
endmodule

// File: rtl/trim_pulse_gen.sv
module trim_pulse_gen #(
   parameter int MIN_TICK_GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   input  logic skip_now,
   input  logic insert_now,
   output logic tick_out
);
   localparam int INS_DELAY = MIN_TICK_GAP / 2;
   localparam int CNT_W     = $clog2(INS_DELAY + 1);

   initial begin
      if (MIN_TICK_GAP < 4) $error("MIN_TICK_GAP must be at least 4");
   end

   logic [CNT_W-1:0] ins_cnt;
   logic             ins_fire;

   assign ins_fire = (ins_cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_out <= 1'b0;
         ins_cnt  <= '0;
      end else begin
         tick_out <= (tick_in && !skip_now) || ins_fire;
         if (insert_now)          ins_cnt <= CNT_W'(INS_DELAY);
         else if (ins_cnt != '0)  ins_cnt <= ins_cnt - 1'b1;
      end
   end

   assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_in && !skip_now) |=> tick_out);
   assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_now |=> !tick_out);
   assert_no_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_out |=> !tick_out);
   assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(skip_now && insert_now));
endmodule

// File: rtl/trim_adjuster.sv
module trim_adjuster #(
   parameter int WINDOW_TICKS = 100000,
   parameter int MIN_TICK_GAP = 8,
   parameter bit SPREAD       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_in,
   input  logic [2:0] trim_code,
   output logic       tick_out
);
   logic skip_now;
   logic insert_now;

   trim_window_ctr #(
      .WINDOW_TICKS (WINDOW_TICKS),
      .CODE_W       (3),
      .SPREAD       (SPREAD)
   ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_in    (tick_in),
      .trim_code  (trim_code),
      .skip_now   (skip_now),
      .insert_now (insert_now)
   );

   trim_pulse_gen #(
      .MIN_TICK_GAP (MIN_TICK_GAP)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_in    (tick_in),
      .skip_now   (skip_now),
      .insert_now (insert_now),
      .tick_out   (tick_out)
   );
endmodule

// File: tb/trim_adjuster_bench.sv
module trim_adjuster_bench;
   localparam int W   = 40;
   localparam int GAP = 8;
   localparam int P   = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b0;
   logic [2:0] trim_code = 3'd0;
   logic       tick_out;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   int cyc = 0;
   int last_cyc = 0;
   int prev_cyc = 0;
   int merges = 0;
   logic prev_out = 1'b0;

   trim_adjuster #(.WINDOW_TICKS(W), .MIN_TICK_GAP(GAP), .SPREAD(1'b1)) u_trim_adjuster (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .trim_code(trim_code), .tick_out(tick_out));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (tick_out) begin
         pulses   <= pulses + 1;
         prev_cyc <= last_cyc;
         last_cyc <= cyc;
      end
      if (tick_out && prev_out) merges <= merges + 1;
      prev_out <= tick_out;
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic feed_tick();
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
      repeat (P - 2) @(negedge clk);
   endtask

   task automatic feed_window(output int cnt);
      int start;
      start = pulses;
      for (int i = 0; i < W; i++) feed_tick();
      cnt = pulses - start;
   endtask

   task automatic test_reset();
      int c;
      check("R1 tick_out at reset", int'(tick_out), 0);
      trim_code = 3'd3;
      feed_window(c);
      check("R1 first window unadjusted", c, W);
      trim_code = 3'd0;
      feed_window(c);
      check("R3 window after code 3", c, W + 3);
   endtask

   task automatic test_latency();
      int c;
      feed_window(c);
      check("R2 code 0 window", c, W);
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
      check("R2 one cycle latency", int'(tick_out), 1);
      @(negedge clk);
      check("R7 strobe width", int'(tick_out), 0);
      repeat (P - 3) @(negedge clk);
      for (int i = 1; i < W; i++) feed_tick();
   endtask

   task automatic test_add(input int m);
      int c;
      trim_code = 3'(m);
      feed_window(c);
      feed_window(c);
      check($sformatf("R3 add %0d", m), c, W + m);
   endtask

   task automatic test_skip(input int m);
      int c;
      trim_code = 3'(4 + m);
      feed_window(c);
      feed_window(c);
      check($sformatf("R4 skip %0d", m), c, W - m);
   endtask

   task automatic test_positions_add();
      int start;
      trim_code = 3'd2;
      feed_window(start);
      start = pulses;
      for (int i = 0; i < 9; i++) feed_tick();
      check("R5 no insert before idx 9", pulses - start, 9);
      feed_tick();
      check("R5 insert at idx 9", pulses - start, 11);
      check("R6 insert delay", last_cyc - prev_cyc, GAP / 2);
      for (int i = 10; i < 20; i++) feed_tick();
      check("R5 insert at idx 19", pulses - start, 22);
      for (int i = 20; i < W; i++) feed_tick();
      check("R5 only two inserts", pulses - start, W + 2);
   endtask

   task automatic test_positions_skip();
      int start;
      trim_code = 3'd5;
      feed_window(start);
      start = pulses;
      for (int i = 0; i < 9; i++) feed_tick();
      check("R9 no skip before idx 9", pulses - start, 9);
      feed_tick();
      check("R9 idx 9 masked", pulses - start, 9);
      for (int i = 10; i < W; i++) feed_tick();
      check("R5 one skip per window", pulses - start, W - 1);
   endtask

   task automatic test_change_mid();
      int start;
      int c;
      trim_code = 3'd3;
      feed_window(c);
      start = pulses;
      for (int i = 0; i < 20; i++) feed_tick();
      trim_code = 3'd7;
      for (int i = 20; i < W; i++) feed_tick();
      check("R8 old code kept in window", pulses - start, W + 3);
      feed_window(c);
      check("R8 new code at boundary", c, W - 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_latency();
      test_add(1);
      test_add(3);
      test_skip(0);
      test_skip(2);
      test_skip(3);
      test_positions_add();
      test_positions_skip();
      test_change_mid();
      check("R7 no merged pulses", merges, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule